// File: doc/BRIEF.md
# Word FIFO with Hysteresis Refill Request

This block is a word-wide FIFO that keeps its fill level in bytes and raises a refill request toward a DMA engine. Each push or pop moves one 32-bit word, which is four bytes. The request line has two trip points. It turns on when the byte fill level falls to or below a programmable low mark. Once on, it stays on while the FIFO fills past that low mark. It turns off only when the free space has shrunk to a programmable number of 32-bit words.

Two 32-bit registers hold the programming. They are reached through plain write and address strobes and read back combinationally. The control register holds a 3-bit granularity field, which sets the turn-off point in free words, and a frame-end flag bit. The flag bit is stored and can be read back, but it has no effect on the FIFO. The alarm register holds the 9-bit low mark in bytes. The default depth is 128 words, or 512 bytes, so every 9-bit low mark is usable. Pushes into a full FIFO and pops from an empty one are dropped, and each leaves a sticky error flag.

Top module: `refill_fifo`

## Requirements
- R1: After reset the fill level is 0, `empty_o`=1, `full_o`=0, both error flags are 0 and `req_o`=1. The control register (word address 0) reads 0x0100_0000 and the alarm register (word address 1) reads 0.
- R2: An accepted push adds 4 to `fill_bytes_o` and an accepted pop subtracts 4. When one push and one pop are both accepted in the same cycle, the fill level is unchanged. The new level is visible in the cycle after the clock edge.
- R3: Words leave in the order they were written. `pop_data_o` always shows the oldest stored word, with no added read latency.
- R4: `full_o` is 1 exactly when the fill level is 512 bytes. `empty_o` is 1 exactly when it is 0.
- R5: A push while the FIFO is full is dropped and sets `overflow_o`. A pop while it is empty is dropped and sets `underflow_o`. Both flags stay set until reset.
- R6: While `req_o` is low, it rises at the clock edge where the updated fill level is less than or equal to the low mark. The low mark is alarm register bits 8:0.
- R7: While `req_o` is high, it stays high until the edge where the updated free space (512 minus fill) is at most 4 times the granularity. The granularity is control register bits 26:24. At that edge it falls.
- R8: With a granularity of 0, the request stays high until the FIFO is completely full.
- R9: A register write changes the thresholds used at the following edge and never clears the current request state by itself.
- R10: Control bit 29 (frame-end flag) is stored and reads back, but it has no effect on the fill level, the data or the request.
- R11: Control reads return only bits 29 and 26:24, and alarm reads return only bits 8:0. All other bits read 0. Writes and reads at word addresses 2 and 3 change nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Write one word |
| push_data_i | input | 32 | Word to write |
| pop_i | input | 1 | Remove the head word |
| pop_data_o | output | 32 | Current head word |
| full_o | output | 1 | FIFO holds 512 bytes |
| empty_o | output | 1 | FIFO holds 0 bytes |
| fill_bytes_o | output | 10 | Fill level in bytes |
| overflow_o | output | 1 | Sticky: push was dropped |
| underflow_o | output | 1 | Sticky: pop was dropped |
| req_o | output | 1 | Refill request with hysteresis |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |

## Verification
Most internal faults surface at the ports within one clock edge.

- **Word counter:** a wrong counter value appears on `fill_bytes_o` and the full/empty flags right after the edge that corrupted it.
- **Request state bit:** a wrong request bit shows as a mismatch on `req_o` at the first fill level that crosses either trip point.
- **Pointers:** a pointer fault is seen only when the corrupted slot reaches the head of the FIFO. At that point `pop_data_o` differs from the expected word in write order.
- **Coverage:** complete fill and drain sweeps under several low-mark and granularity settings make every step of the count and every crossing of each trip point observable.

// File: rtl/refill_fifo_pkg.sv
package refill_fifo_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ALARM_W  = 9;
  localparam int unsigned GRAN_W   = 3;
  localparam int unsigned GRAN_LSB = 24;
  localparam int unsigned EOF_BIT  = 29;
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_ALARM = 1;
  localparam logic [GRAN_W-1:0] GRAN_RST = 3'd1;

  typedef struct packed {
    logic              eof;
    logic [GRAN_W-1:0] gran;
  } ctrl_t;
endpackage

// File: rtl/rf_regs.sv
module rf_regs
  import refill_fifo_pkg::*;
#(
  parameter int unsigned REG_AW = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  rdata_o,
  output ctrl_t              ctrl_o,
  output logic [ALARM_W-1:0] alarm_o
);
  logic  sel_ctrl, sel_alarm;
  ctrl_t ctrl_q;
  logic [ALARM_W-1:0] alarm_q;

  assign sel_ctrl  = (addr_i == REG_AW'(ADDR_CTRL));
  assign sel_alarm = (addr_i == REG_AW'(ADDR_ALARM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '{eof: 1'b0, gran: GRAN_RST};
      alarm_q <= '0;
    end else if (we_i) begin
      if (sel_ctrl) begin
        ctrl_q.eof  <= wdata_i[EOF_BIT];
        ctrl_q.gran <= wdata_i[GRAN_LSB +: GRAN_W];
      end
      if (sel_alarm) alarm_q <= wdata_i[ALARM_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      rdata_o[EOF_BIT]             = ctrl_q.eof;
      rdata_o[GRAN_LSB +: GRAN_W]  = ctrl_q.gran;
    end else if (sel_alarm) begin
      rdata_o[ALARM_W-1:0] = alarm_q;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign alarm_o = alarm_q;
endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int unsigned DEPTH_W = 128,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned PTR_W  = (DEPTH_W > 1) ? $clog2(DEPTH_W) : 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cnt_n_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              ovf_o,
  output logic              udf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH_W);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH_W - 1);

  logic [DATA_W-1:0] mem_q [DEPTH_W];
  logic [PTR_W-1:0]  wr_q, rd_q, wr_n, rd_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              push_ok, pop_ok, ovf_q, udf_q;

  assign full_o  = (cnt_q == CNT_MAX);
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  // pointer wrap: free for power-of-two depth, compare otherwise
  generate
    if ((DEPTH_W & (DEPTH_W - 1)) == 0) begin : g_wrap_pow2
      assign wr_n = wr_q + PTR_W'(1);
      assign rd_n = rd_q + PTR_W'(1);
    end else begin : g_wrap_cmp
      assign wr_n = (wr_q == PTR_LAST) ? '0 : wr_q + PTR_W'(1);
      assign rd_n = (rd_q == PTR_LAST) ? '0 : rd_q + PTR_W'(1);
    end
  endgenerate

  always_comb begin
    unique case ({push_ok, pop_ok})
      2'b10:   cnt_n = cnt_q + CNT_W'(1);
      2'b01:   cnt_n = cnt_q - CNT_W'(1);
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (push_ok) wr_q <= wr_n;
      if (pop_ok)  rd_q <= rd_n;
      cnt_q <= cnt_n;
      if (push_i && !push_ok) ovf_q <= 1'b1;
      if (pop_i && !pop_ok)   udf_q <= 1'b1;
    end
  end

  assign data_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;
  assign cnt_n_o = cnt_n;
  assign ovf_o   = ovf_q;
  assign udf_o   = udf_q;
endmodule

// File: rtl/rf_hyst.sv
module rf_hyst #(
  parameter int unsigned FILL_W      = 10,
  parameter int unsigned DEPTH_BYTES = 512,
  parameter int unsigned ALARM_W     = 9,
  parameter int unsigned GRAN_W      = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FILL_W-1:0]  fill_n_i,
  input  logic [ALARM_W-1:0] alarm_i,
  input  logic [GRAN_W-1:0]  gran_i,
  output logic               req_o
);
  logic [FILL_W-1:0] free_n, hi_mark, lo_mark;
  logic              req_q, req_d;

  assign free_n  = FILL_W'(DEPTH_BYTES) - fill_n_i;
  assign hi_mark = FILL_W'({gran_i, 2'b00});
  assign lo_mark = FILL_W'(alarm_i);

  // on: stay until free space shrinks to hi_mark; off: wake at lo_mark
  assign req_d = req_q ? (free_n > hi_mark) : (fill_n_i <= lo_mark);

  // empty FIFO after reset meets any low mark
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b1;
    else         req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/refill_fifo.sv
module refill_fifo
  import refill_fifo_pkg::*;
#(
  parameter int unsigned DEPTH_W = 128,
  parameter int unsigned REG_AW  = 2,
  localparam int unsigned CNT_W  = $clog2(DEPTH_W + 1),
  localparam int unsigned FILL_W = CNT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] pop_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [FILL_W-1:0] fill_bytes_o,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic              req_o,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o
);
  localparam int unsigned DEPTH_BYTES = DEPTH_W * 4;

  ctrl_t              ctrl_q;
  logic [ALARM_W-1:0] alarm_q;
  logic [GRAN_W-1:0]  gran_q;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               ctrl_eof_unused;

  rf_regs #(.REG_AW(REG_AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ctrl_o  (ctrl_q),
    .alarm_o (alarm_q)
  );

  assign gran_q          = ctrl_q.gran;
  assign ctrl_eof_unused = ctrl_q.eof;

  rf_store #(.DEPTH_W(DEPTH_W), .DATA_W(WORD_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .data_i  (push_data_i),
    .pop_i   (pop_i),
    .data_o  (pop_data_o),
    .cnt_o   (cnt_q),
    .cnt_n_o (cnt_n),
    .full_o  (full_o),
    .empty_o (empty_o),
    .ovf_o   (overflow_o),
    .udf_o   (underflow_o)
  );

  rf_hyst #(
    .FILL_W(FILL_W), .DEPTH_BYTES(DEPTH_BYTES), .ALARM_W(ALARM_W), .GRAN_W(GRAN_W)
  ) u_hyst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fill_n_i ({cnt_n, 2'b00}),
    .alarm_i  (alarm_q),
    .gran_i   (gran_q),
    .req_o    (req_o)
  );

  assign fill_bytes_o = {cnt_q, 2'b00};
endmodule

// File: rtl/refill_fifo_chk.sv
module refill_fifo_chk #(
  parameter int unsigned FILL_W      = 10,
  parameter int unsigned DEPTH_BYTES = 512
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic              full_o,
  input logic              empty_o,
  input logic [FILL_W-1:0] fill_bytes_o,
  input logic              overflow_o,
  input logic              underflow_o,
  input logic              req_o,
  input logic [8:0]        alarm_q,
  input logic [2:0]        gran_q
);
  logic [FILL_W-1:0] free_b, hi_b;
  assign free_b = FILL_W'(DEPTH_BYTES) - fill_bytes_o;
  assign hi_b   = FILL_W'({gran_q, 2'b00});

  assert_fill_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_bytes_o == $past(fill_bytes_o)) || (fill_bytes_o == $past(fill_bytes_o) + FILL_W'(4)) ||
    (fill_bytes_o == $past(fill_bytes_o) - FILL_W'(4)));

  assert_flag_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o) && (!full_o || fill_bytes_o == FILL_W'(DEPTH_BYTES)));

  assert_push_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> ($stable(fill_bytes_o) && overflow_o));

  assert_pop_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> ($stable(fill_bytes_o) && underflow_o));

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o || underflow_o) |=> ($past(overflow_o) -> overflow_o) && ($past(underflow_o) -> underflow_o));

  assert_req_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> (fill_bytes_o <= FILL_W'($past(alarm_q))));

  assert_req_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> (free_b <= FILL_W'({$past(gran_q), 2'b00})));

  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && $stable(fill_bytes_o) && $stable(gran_q) && free_b > hi_b) |=> req_o || (free_b <= hi_b) || !$stable(gran_q));
endmodule

bind refill_fifo refill_fifo_chk #(.FILL_W(FILL_W), .DEPTH_BYTES(DEPTH_BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_i       (push_i),
  .pop_i        (pop_i),
  .full_o       (full_o),
  .empty_o      (empty_o),
  .fill_bytes_o (fill_bytes_o),
  .overflow_o   (overflow_o),
  .underflow_o  (underflow_o),
  .req_o        (req_o),
  .alarm_q      (alarm_q),
  .gran_q       (gran_q)
);

// File: tb/sim_refill_fifo.sv
module sim_refill_fifo;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0;
  logic [31:0] push_data_i = '0;
  logic [31:0] pop_data_o;
  logic        full_o, empty_o, overflow_o, underflow_o, req_o;
  logic [9:0]  fill_bytes_o;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;

  int errs = 0, checks = 0;
  int m_cnt = 0, m_alarm = 0, m_gran = 1, m_wr = 0, m_rd = 0;
  bit m_req = 1, m_ovf = 0, m_udf = 0;

  always #2 clk_i = ~clk_i;

  refill_fifo u0 (.*);

  function automatic logic [31:0] pat(int s);
    return (32'(s) * 32'h9E37_79B9) ^ 32'h5A5A_0000;
  endfunction

  // reference model, sampled at each rising edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_alarm = 0; m_gran = 1; m_wr = 0; m_rd = 0;
      m_req = 1; m_ovf = 0; m_udf = 0;
    end else begin
      automatic bit pok = push_i && (m_cnt < 128);
      automatic bit qok = pop_i && (m_cnt > 0);
      automatic int fill;
      if (push_i && !pok) m_ovf = 1;
      if (pop_i && !qok)  m_udf = 1;
      m_cnt = m_cnt + int'(pok) - int'(qok);
      if (pok) m_wr++;
      if (qok) m_rd++;
      fill = m_cnt * 4;
      m_req = m_req ? ((512 - fill) > 4 * m_gran) : (fill <= m_alarm);
      if (reg_we_i && reg_addr_i == 2'd0) m_gran = int'(reg_wdata_i[26:24]);
      if (reg_we_i && reg_addr_i == 2'd1) m_alarm = int'(reg_wdata_i[8:0]);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic verify();
    chk("R2 fill", 32'(fill_bytes_o), 32'(m_cnt * 4));
    chk("R4 full", 32'(full_o), 32'(m_cnt == 128));
    chk("R4 empty", 32'(empty_o), 32'(m_cnt == 0));
    chk("R6 R7 R8 req", 32'(req_o), 32'(m_req));
    chk("R5 overflow", 32'(overflow_o), 32'(m_ovf));
    chk("R5 underflow", 32'(underflow_o), 32'(m_udf));
  endtask

  task automatic cycle(bit p, bit q);
    @(negedge clk_i);
    push_i = p; pop_i = q; push_data_i = pat(m_wr);
    if (q && m_cnt > 0) chk("R3 head", pop_data_o, pat(m_rd));
    @(posedge clk_i);
    #1; push_i = 0; pop_i = 0;
    verify();
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    #1; reg_we_i = 0;
    verify();
  endtask

  task automatic rreg(string tag, logic [1:0] a, logic [31:0] exp);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 chk(tag, reg_rdata_o, exp);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errs++; checks++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    // R1 reset state
    chk("R1 fill", 32'(fill_bytes_o), 0);
    chk("R1 empty", 32'(empty_o), 1);
    chk("R1 full", 32'(full_o), 0);
    chk("R1 req", 32'(req_o), 1);
    chk("R1 flags", 32'({overflow_o, underflow_o}), 0);
    rreg("R1 ctrl", 2'd0, 32'h0100_0000);
    rreg("R1 alarm", 2'd1, 32'h0);

    // R5 pop on empty
    cycle(0, 1);

    // R6 R7 R8 sweeps over (alarm, granularity) settings
    for (int c = 0; c < 6; c++) begin
      automatic int al = (c == 0) ? 0 : (c == 1) ? 32 : (c == 2) ? 100 :
                         (c == 3) ? 511 : (c == 4) ? 256 : 508;
      automatic int gr = (c == 0) ? 1 : (c == 1) ? 0 : (c == 2) ? 7 :
                         (c == 3) ? 3 : (c == 4) ? 2 : 0;
      wreg(2'd1, 32'(al));
      wreg(2'd0, 32'(gr) << 24);
      for (int i = 0; i < 128; i++) cycle(1, 0);
      cycle(1, 0);  // R5 push on full
      for (int i = 0; i < 128; i++) cycle(0, 1);
    end

    // R2 simultaneous push and pop at a mid level
    for (int i = 0; i < 10; i++) cycle(1, 0);
    for (int i = 0; i < 20; i++) cycle(1, 1);
    chk("R2 both", 32'(fill_bytes_o), 40);
    for (int i = 0; i < 10; i++) cycle(0, 1);

    // R9 writes retarget without clearing state
    wreg(2'd1, 32'd0);
    wreg(2'd0, 32'h0100_0000);
    for (int i = 0; i < 122; i++) cycle(1, 0);
    chk("R9 req before", 32'(req_o), 1);
    wreg(2'd0, 32'h0700_0000);
    chk("R9 req kept", 32'(req_o), 1);
    cycle(0, 0);
    chk("R9 req after", 32'(req_o), 0);
    for (int i = 0; i < 122; i++) cycle(0, 1);

    // R10 frame-end flag stored, no effect
    wreg(2'd0, 32'h2100_0000);
    rreg("R10 ctrl", 2'd0, 32'h2100_0000);
    for (int i = 0; i < 130; i++) cycle(1, 0);
    for (int i = 0; i < 130; i++) cycle(0, 1);

    // R11 reserved bits and unused addresses
    wreg(2'd0, 32'hFFFF_FFFF);
    rreg("R11 ctrl", 2'd0, 32'h2700_0000);
    wreg(2'd1, 32'hFFFF_FFFF);
    rreg("R11 alarm", 2'd1, 32'h0000_01FF);
    wreg(2'd2, 32'h0000_0000);
    wreg(2'd3, 32'h0000_0000);
    rreg("R11 addr2", 2'd2, 32'h0);
    rreg("R11 ctrl kept", 2'd0, 32'h2700_0000);
    rreg("R11 alarm kept", 2'd1, 32'h0000_01FF);
    cycle(0, 0);

    finish_run();
  end
endmodule